// File: doc/BRIEF.md
# Card Command Issuer

This block sends one command to a card-side command port and records how the card replied. A host writes an argument register and then a command word. When the command word carries the enable flag, the block presents the command index and the argument on a valid/ready request port. It then waits for the card's reply. The reply carries a reject flag, a byte count and up to sixteen response bytes.

The reply is checked against the kind of response the command word asked for. A good reply is unpacked into four 32-bit response words. The result is recorded as one of three sticky status flags: command sent, response received, or timeout. The enable flag in the stored command word then clears itself. One cycle later, a single-cycle pulse tells a neighbouring data engine that it may start a transfer that was armed earlier. A command word with the pending flag set is stored but never sent.

The control path is a four-state machine:
- ST_IDLE moves to ST_ISSUE on an accepted command write that has enable set and pending clear.
- ST_ISSUE moves to ST_WAIT when the card takes the request (ready high).
- ST_WAIT moves to ST_KICK when the reply arrives (reply valid high).
- ST_KICK always returns to ST_IDLE after one cycle.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset, the status is 0, all four response words are 0, the stored command is 0, and both the request valid and the data-kick outputs are low.
- R2: A command write with enable (bit 10) set and pending (bit 9) clear raises the request valid in the next cycle. The request carries the index from bits 5:0 and the argument register value. Valid stays high, with both fields unchanged, until ready is seen.
- R3: If bit 6 (response expected) is clear and the card does not reject, status bit 7 (sent) is set and the response words are left unchanged.
- R4: If a response is expected and 4 bytes return, word 0 takes bytes 0 to 3 big-endian, so byte 0 lands in bits 31:24, and words 1 to 3 are cleared. Status bit 6 (response end) is set. On the reply port, byte k is card_rsp_data[127-8k -: 8]. On the response output, word i is resp_words[32i +: 32].
- R5: If a response is expected and 16 bytes return, all four words are filled in the same big-endian way, with bit 0 of word 3 forced to 0. Status bit 6 is set. This holds whether or not bit 7 (long) asked for a long reply.
- R6: Status bit 2 (timeout) is set, and the response words are left unchanged, in each of these cases:
  - the card rejects the command;
  - a response is expected and the length is 0;
  - a response is expected and the length is neither 4 nor 16;
  - bit 7 asks for a long reply but 4 bytes return.
- R7: The stored command reads back what was written, with bit 10 cleared once the command has been handled. A write without bit 10 is stored and sends nothing.
- R8: With bit 9 set, the command is stored with bit 10 cleared, no request is made and no kick follows. Bit 8 (interrupt wait) on its own does not stop a normal issue.
- R9: Every issued command ends with exactly one data-kick pulse, in the cycle after the reply is accepted.
- R10: Status bit 11 (active) is high from the cycle after an issuing write until the kick cycle has ended. While it is high, writes to the command and argument registers are ignored.
- R11: A clear write drops each status bit 10:0 that is set in its mask. A flag being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 11 | Command word to write |
| arg_wr_en | input | 1 | Argument register write strobe |
| arg_wr_data | input | 32 | Argument value to write |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 11 | Status bits to clear |
| cmd_value | output | 11 | Stored command word |
| status | output | 12 | Sticky flags in bits 10:0, active flag in bit 11 |
| resp_words | output | 128 | Response words, word i at bits 32i+31:32i |
| data_kick | output | 1 | One-cycle start pulse to the data engine |
| card_req_valid | output | 1 | Request valid toward the card |
| card_req_ready | input | 1 | Card takes the request |
| card_req_index | output | 6 | Command index sent to the card |
| card_req_arg | output | 32 | Argument sent to the card |
| card_rsp_valid | input | 1 | Reply from the card is valid |
| card_rsp_reject | input | 1 | Card refused the command |
| card_rsp_len | input | 5 | Number of reply bytes |
| card_rsp_data | input | 128 | Reply bytes, byte 0 in the top bits |

## Verification
Two functions can land in the same cycle: the capture of an outcome flag when the reply is taken, and a host clear of the status. The bench provokes this by waiting until the card model raises reply valid, then driving a clear of every status bit in that same cycle. A timeout flag from an earlier command is still set at that point. The expected result is that the new sent flag survives while the old timeout flag is removed. A second test clears only one flag while another stays set.

// File: rtl/cmdiss_pkg.sv
package cmdiss_pkg;
    localparam int CMD_W        = 11;
    localparam int CMD_IDX_W    = 6;
    localparam int CMD_RESP_BIT = 6;
    localparam int CMD_LONG_BIT = 7;
    localparam int CMD_IRQ_BIT  = 8;
    localparam int CMD_PEND_BIT = 9;
    localparam int CMD_EN_BIT   = 10;

    localparam int STS_STICKY_W = 11;
    localparam int STS_W        = STS_STICKY_W + 1;
    localparam int STS_TMO      = 2;
    localparam int STS_RESPEND  = 6;
    localparam int STS_SENT     = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_KICK  = 2'd3
    } cmd_state_e;

    typedef struct packed {
        logic sent;
        logic resp;
        logic tmo;
    } outcome_t;
endpackage

// File: rtl/cmdiss_fsm.sv
module cmdiss_fsm
    import cmdiss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_en,
    input  logic [CMD_W-1:0] cmd_wr_data,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic [CMD_W-1:0] cmd_q,
    output logic             req_valid,
    output logic             rsp_take,
    output logic             data_kick,
    output logic             busy
);
    cmd_state_e state_q;
    cmd_state_e state_d;
    logic       wr_accept;
    logic       wr_issue;

    assign wr_accept = (state_q == ST_IDLE) && cmd_wr_en;
    assign wr_issue  = wr_accept && cmd_wr_data[CMD_EN_BIT] && !cmd_wr_data[CMD_PEND_BIT];

    // state register and stored command word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_accept) begin
                cmd_q <= cmd_wr_data;
                if (cmd_wr_data[CMD_PEND_BIT]) begin
                    cmd_q[CMD_EN_BIT] <= 1'b0;
                end
            end else if (rsp_take) begin
                cmd_q[CMD_EN_BIT] <= 1'b0;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_issue)  state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_KICK;
            ST_KICK:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        req_valid = 1'b0;
        rsp_take  = 1'b0;
        data_kick = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy      = 1'b0;
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  rsp_take  = rsp_valid;
            ST_KICK:  data_kick = 1'b1;
            default:  busy      = 1'b0;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid); // R2
    AST_PEND_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && cmd_wr_data[CMD_PEND_BIT]) |=> (!req_valid && !busy)); // R8
    AST_EN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        data_kick |-> !cmd_q[CMD_EN_BIT]); // R7
    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_kick |=> !data_kick); // R9
    AST_KICK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        data_kick |-> $past(rsp_take)); // R9
endmodule

// File: rtl/cmdiss_resp_check.sv
module cmdiss_resp_check
    import cmdiss_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                          expect_resp,
    input  logic                          expect_long,
    input  logic                          reject,
    input  logic [LEN_W-1:0]              len,
    input  logic [RSP_WORDS*WORD_W-1:0]   bytes_in,
    output outcome_t                      outcome,
    output logic                          full_len,
    output logic [RSP_WORDS*WORD_W-1:0]   words_out
);
    localparam int TOT_W       = RSP_WORDS * WORD_W;
    localparam int SHORT_BYTES = WORD_W / 8;
    localparam int LONG_BYTES  = TOT_W / 8;
    localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(SHORT_BYTES);
    localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(LONG_BYTES);

    logic is_short;
    logic len_bad;

    assign is_short = (len == SHORT_LEN);
    assign full_len = (len == LONG_LEN);
    assign len_bad  = !(is_short || full_len) || (expect_long && is_short);

    always_comb begin
        outcome = '0;
        if (reject) begin
            outcome.tmo = 1'b1;
        end else if (!expect_resp) begin
            outcome.sent = 1'b1;
        end else if (len_bad) begin
            outcome.tmo = 1'b1;
        end else begin
            outcome.resp = 1'b1;
        end
    end

    // word i takes bytes SHORT_BYTES*i onward, first byte most significant
    for (genvar gi = 0; gi < RSP_WORDS; gi++) begin : g_word
        logic [WORD_W-1:0] slice;
        assign slice = bytes_in[TOT_W-1-gi*WORD_W -: WORD_W];
        if (gi == 0) begin : g_first
            assign words_out[gi*WORD_W +: WORD_W] = slice;
        end else if (gi == RSP_WORDS - 1) begin : g_last
            assign words_out[gi*WORD_W +: WORD_W] =
                full_len ? {slice[WORD_W-1:1], 1'b0} : '0;
        end else begin : g_mid
            assign words_out[gi*WORD_W +: WORD_W] = full_len ? slice : '0;
        end
    end
endmodule

// File: rtl/cmdiss_status.sv
module cmdiss_status
    import cmdiss_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  outcome_t                set_val,
    input  logic                    clr_en,
    input  logic [STS_STICKY_W-1:0] clr_mask,
    input  logic                    busy,
    output logic [STS_W-1:0]        status
);
    logic [STS_STICKY_W-1:0] sticky_q;
    logic [STS_STICKY_W-1:0] set_vec;
    logic [STS_STICKY_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        if (set_en) begin
            set_vec[STS_TMO]     = set_val.tmo;
            set_vec[STS_RESPEND] = set_val.resp;
            set_vec[STS_SENT]    = set_val.sent;
        end
    end

    assign clr_vec = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (sticky_q & ~clr_vec) | set_vec;
        end
    end

    assign status = {busy, sticky_q};

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ($countones({set_val.tmo, set_val.resp, set_val.sent}) == 1)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_val.sent) |=> status[STS_SENT]); // R11
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_mask[STS_TMO] && !(set_en && set_val.tmo)) |=> !status[STS_TMO]); // R11
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
    import cmdiss_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr_en,
    input  logic [CMD_W-1:0]            cmd_wr_data,
    input  logic                        arg_wr_en,
    input  logic [ARG_W-1:0]            arg_wr_data,
    input  logic                        sts_clr_en,
    input  logic [STS_STICKY_W-1:0]     sts_clr_mask,
    output logic [CMD_W-1:0]            cmd_value,
    output logic [STS_W-1:0]            status,
    output logic [RSP_WORDS*WORD_W-1:0] resp_words,
    output logic                        data_kick,
    output logic                        card_req_valid,
    input  logic                        card_req_ready,
    output logic [CMD_IDX_W-1:0]        card_req_index,
    output logic [ARG_W-1:0]            card_req_arg,
    input  logic                        card_rsp_valid,
    input  logic                        card_rsp_reject,
    input  logic [LEN_W-1:0]            card_rsp_len,
    input  logic [RSP_WORDS*WORD_W-1:0] card_rsp_data
);
    localparam int TOT_W = RSP_WORDS * WORD_W;

    logic [CMD_W-1:0] cmd_q;
    logic [ARG_W-1:0] arg_q;
    logic             rsp_take;
    logic             busy;
    outcome_t         outcome;
    logic             full_len;
    logic [TOT_W-1:0] words_new;
    logic [TOT_W-1:0] resp_q;

    cmdiss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_wr_data(cmd_wr_data),
        .req_ready  (card_req_ready),
        .rsp_valid  (card_rsp_valid),
        .cmd_q      (cmd_q),
        .req_valid  (card_req_valid),
        .rsp_take   (rsp_take),
        .data_kick  (data_kick),
        .busy       (busy)
    );

    cmdiss_resp_check #(
        .WORD_W   (WORD_W),
        .RSP_WORDS(RSP_WORDS),
        .LEN_W    (LEN_W)
    ) u_check (
        .expect_resp(cmd_q[CMD_RESP_BIT]),
        .expect_long(cmd_q[CMD_LONG_BIT]),
        .reject     (card_rsp_reject),
        .len        (card_rsp_len),
        .bytes_in   (card_rsp_data),
        .outcome    (outcome),
        .full_len   (full_len),
        .words_out  (words_new)
    );

    cmdiss_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (rsp_take),
        .set_val (outcome),
        .clr_en  (sts_clr_en),
        .clr_mask(sts_clr_mask),
        .busy    (busy),
        .status  (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            resp_q <= '0;
        end else begin
            if (arg_wr_en && !busy) begin
                arg_q <= arg_wr_data;
            end
            if (rsp_take && outcome.resp) begin
                resp_q <= words_new;
            end
        end
    end

    assign cmd_value      = cmd_q;
    assign resp_words     = resp_q;
    assign card_req_index = cmd_q[CMD_IDX_W-1:0];
    assign card_req_arg   = arg_q;

    AST_LONG_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && outcome.resp && full_len) |=> !resp_words[(RSP_WORDS-1)*WORD_W]); // R5
    AST_RESP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && !outcome.resp) |=> $stable(resp_words)); // R6
    AST_ARG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arg_wr_en) |=> $stable(card_req_arg)); // R10
endmodule

// File: tb/sim_card_cmd_issuer.sv
module sim_card_cmd_issuer;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_wr_en;
    logic [10:0]  cmd_wr_data;
    logic         arg_wr_en;
    logic [31:0]  arg_wr_data;
    logic         sts_clr_en;
    logic [10:0]  sts_clr_mask;
    logic [10:0]  cmd_value;
    logic [11:0]  status;
    logic [127:0] resp_words;
    logic         data_kick;
    logic         card_req_valid;
    logic         card_req_ready;
    logic [5:0]   card_req_index;
    logic [31:0]  card_req_arg;
    logic         card_rsp_valid;
    logic         card_rsp_reject;
    logic [4:0]   card_rsp_len;
    logic [127:0] card_rsp_data;

    card_cmd_issuer u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .arg_wr_en(arg_wr_en), .arg_wr_data(arg_wr_data),
        .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
        .cmd_value(cmd_value), .status(status), .resp_words(resp_words),
        .data_kick(data_kick),
        .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
        .card_req_index(card_req_index), .card_req_arg(card_req_arg),
        .card_rsp_valid(card_rsp_valid), .card_rsp_reject(card_rsp_reject),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [127:0] D1 = 128'hA1B2C3D4_11223344_55667788_99AABBCF;
    localparam logic [127:0] D2 = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    localparam logic [127:0] W_D1_SHORT = {96'h0, 32'hA1B2C3D4};
    localparam logic [127:0] W_D1_LONG  = {32'h99AABBCE, 32'h55667788, 32'h11223344, 32'hA1B2C3D4};
    localparam logic [127:0] W_D2_SHORT = {96'h0, 32'h0F0E0D0C};
    localparam logic [127:0] W_D2_LONG  = {32'h03020100, 32'h07060504, 32'h0B0A0908, 32'h0F0E0D0C};

    typedef struct {
        int           rn;
        logic [10:0]  sts;
        logic [127:0] words;
        logic [10:0]  cmdv;
        logic [5:0]   idx;
        logic [31:0]  arg;
    } exp_t;

    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rsp_cyc = 0;
    int kicks = 0;
    bit done_flag = 0;

    int           cfg_ready_wait = 0;
    int           cfg_rsp_wait = 0;
    logic         cfg_reject = 1'b0;
    logic [4:0]   cfg_len = 5'd0;
    logic [127:0] cfg_data = '0;
    logic [5:0]   seen_idx;
    logic [31:0]  seen_arg;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // card model: takes the request, then replies with the configured data
    initial begin
        card_req_ready  = 1'b0;
        card_rsp_valid  = 1'b0;
        card_rsp_reject = 1'b0;
        card_rsp_len    = '0;
        card_rsp_data   = '0;
        forever begin
            @(negedge clk);
            if (card_req_valid === 1'b1) begin
                repeat (cfg_ready_wait) @(negedge clk);
                card_req_ready = 1'b1;
                seen_idx = card_req_index;
                seen_arg = card_req_arg;
                @(negedge clk);
                card_req_ready = 1'b0;
                repeat (cfg_rsp_wait) @(negedge clk);
                card_rsp_valid  = 1'b1;
                card_rsp_reject = cfg_reject;
                card_rsp_len    = cfg_len;
                card_rsp_data   = cfg_data;
                rsp_cyc = cyc;
                @(negedge clk);
                card_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: pops the scoreboard on each kick pulse
    initial begin
        forever begin
            @(negedge clk);
            if (data_kick === 1'b1) begin
                kicks++;
                chk(cyc == rsp_cyc + 1, "R9 kick one cycle after reply",
                    128'(cyc), 128'(rsp_cyc + 1));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 kick with nothing expected", 128'd1, 128'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(status[10:0] == e.sts, $sformatf("R%0d status", e.rn),
                        128'(status[10:0]), 128'(e.sts));
                    chk(resp_words == e.words, $sformatf("R%0d response words", e.rn),
                        resp_words, e.words);
                    chk(cmd_value == e.cmdv, "R7 stored command after handling",
                        128'(cmd_value), 128'(e.cmdv));
                    chk(seen_idx == e.idx && seen_arg == e.arg, "R2 request fields",
                        {90'h0, seen_idx, seen_arg}, {90'h0, e.idx, e.arg});
                end
            end
        end
    end

    task automatic start_cmd(input logic [10:0] c, input logic [31:0] a, input bit preclear);
        @(negedge clk);
        if (preclear) begin
            sts_clr_en   = 1'b1;
            sts_clr_mask = '1;
        end
        arg_wr_en   = 1'b1;
        arg_wr_data = a;
        @(negedge clk);
        sts_clr_en  = 1'b0;
        arg_wr_en   = 1'b0;
        cmd_wr_en   = 1'b1;
        cmd_wr_data = c;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        chk(status[11] == 1'b1, "R10 active after issuing write", 128'(status[11]), 128'd1);
    endtask

    task automatic wait_idle();
        while (status[11] === 1'b1) @(negedge clk);
    endtask

    task automatic push_exp(input int rn, input logic [10:0] sts, input logic [127:0] w,
                            input logic [10:0] c, input logic [31:0] a);
        exp_t e;
        e.rn = rn; e.sts = sts; e.words = w;
        e.cmdv = c & 11'h3FF; e.idx = c[5:0]; e.arg = a;
        exp_q.push_back(e);
    endtask

    task automatic run(input int rn, input logic [10:0] c, input logic [31:0] a,
                       input logic rej, input logic [4:0] len, input logic [127:0] d,
                       input logic [10:0] sts, input logic [127:0] w);
        cfg_reject = rej; cfg_len = len; cfg_data = d;
        push_exp(rn, sts, w, c, a);
        start_cmd(c, a, 1'b1);
        wait_idle();
        chk(status[11] == 1'b0, "R10 active low after kick", 128'(status[11]), 128'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_wr_en = 1'b0; cmd_wr_data = '0;
        arg_wr_en = 1'b0; arg_wr_data = '0;
        sts_clr_en = 1'b0; sts_clr_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 12'h0, "R1 status", 128'(status), 128'd0);
        chk(resp_words == '0, "R1 response words", resp_words, 128'd0);
        chk(cmd_value == '0, "R1 stored command", 128'(cmd_value), 128'd0);
        chk(card_req_valid == 1'b0 && data_kick == 1'b0, "R1 request and kick low",
            {126'h0, card_req_valid, data_kick}, 128'd0);

        // R3 no response expected
        run(3, 11'h405, 32'hDEAD0001, 1'b0, 5'd0, D1, 11'h080, 128'd0);
        // R4 short reply
        run(4, 11'h451, 32'h00000011, 1'b0, 5'd4, D1, 11'h040, W_D1_SHORT);
        // R5 long reply, word 3 bit 0 forced low
        run(5, 11'h4C2, 32'h00000022, 1'b0, 5'd16, D1, 11'h040, W_D1_LONG);
        // R5 sixteen bytes while only a short reply was asked
        run(5, 11'h443, 32'h00000033, 1'b0, 5'd16, D2, 11'h040, W_D2_LONG);
        // R6 timeout cases, words unchanged
        run(6, 11'h441, 32'h00000044, 1'b1, 5'd4, D1, 11'h004, W_D2_LONG);
        run(6, 11'h444, 32'h00000055, 1'b0, 5'd0, D1, 11'h004, W_D2_LONG);
        run(6, 11'h4C5, 32'h00000066, 1'b0, 5'd4, D1, 11'h004, W_D2_LONG);
        run(6, 11'h446, 32'h00000077, 1'b0, 5'd8, D1, 11'h004, W_D2_LONG);
        run(6, 11'h405, 32'h00000088, 1'b1, 5'd0, D1, 11'h004, W_D2_LONG);
        // R8 interrupt-wait flag alone still issues
        run(8, 11'h549, 32'h00000099, 1'b0, 5'd4, D2, 11'h040, W_D2_SHORT);

        // R10 writes while busy are ignored
        begin
            int k0;
            cfg_ready_wait = 3; cfg_rsp_wait = 6;
            cfg_reject = 1'b0; cfg_len = 5'd4; cfg_data = D1;
            push_exp(10, 11'h040, W_D1_SHORT, 11'h452, 32'hCAFE0002);
            start_cmd(11'h452, 32'hCAFE0002, 1'b1);
            repeat (5) @(negedge clk);
            cmd_wr_en = 1'b1; cmd_wr_data = 11'h4FF;
            arg_wr_en = 1'b1; arg_wr_data = 32'h12345678;
            @(negedge clk);
            cmd_wr_en = 1'b0; arg_wr_en = 1'b0;
            wait_idle();
            k0 = kicks;
            repeat (3) @(negedge clk);
            chk(card_req_valid == 1'b0 && kicks == k0, "R10 busy write did not issue",
                128'(card_req_valid), 128'd0);
            chk(cmd_value == 11'h052, "R10 busy write not stored", 128'(cmd_value), 128'h052);
            chk(card_req_arg == 32'hCAFE0002, "R10 busy argument write ignored",
                128'(card_req_arg), 128'hCAFE0002);
            cfg_ready_wait = 0; cfg_rsp_wait = 0;
        end

        // R11 set and clear in the same cycle: set wins, older flag drops
        run(11, 11'h407, 32'h000000AA, 1'b1, 5'd0, D1, 11'h004, W_D1_SHORT);
        cfg_rsp_wait = 2; cfg_reject = 1'b0; cfg_len = 5'd0;
        push_exp(11, 11'h080, W_D1_SHORT, 11'h408, 32'h000000BB);
        start_cmd(11'h408, 32'h000000BB, 1'b0);
        wait (card_rsp_valid === 1'b1);
        sts_clr_en = 1'b1; sts_clr_mask = '1;
        @(negedge clk);
        sts_clr_en = 1'b0;
        wait_idle();
        cfg_rsp_wait = 0;

        // R11 clearing one flag keeps the other
        cfg_reject = 1'b1;
        push_exp(11, 11'h084, W_D1_SHORT, 11'h409, 32'h000000CC);
        start_cmd(11'h409, 32'h000000CC, 1'b0);
        wait_idle();
        @(negedge clk);
        sts_clr_en = 1'b1; sts_clr_mask = 11'h080;
        @(negedge clk);
        sts_clr_en = 1'b0;
        chk(status[10:0] == 11'h004, "R11 single-bit clear", 128'(status[10:0]), 128'h004);

        // R8 pending flag: stored without enable, nothing sent
        begin
            int k0;
            k0 = kicks;
            @(negedge clk);
            cmd_wr_en = 1'b1; cmd_wr_data = 11'h603;
            @(negedge clk);
            cmd_wr_en = 1'b0;
            chk(cmd_value == 11'h203, "R8 pending stored without enable",
                128'(cmd_value), 128'h203);
            repeat (4) @(negedge clk);
            chk(card_req_valid == 1'b0 && status[11] == 1'b0 && kicks == k0,
                "R8 pending issued nothing", {126'h0, card_req_valid, status[11]}, 128'd0);
            // R7 write without enable just stores
            cmd_wr_en = 1'b1; cmd_wr_data = 11'h0C5;
            @(negedge clk);
            cmd_wr_en = 1'b0;
            repeat (3) @(negedge clk);
            chk(cmd_value == 11'h0C5 && card_req_valid == 1'b0 && kicks == k0,
                "R7 write without enable", 128'(cmd_value), 128'h0C5);
        end

        chk(exp_q.size() == 0, "R9 every issued command kicked", 128'(exp_q.size()), 128'd0);
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end
endmodule